// File: doc/BRIEF.md
# Receive Error Status Accumulator

This block produces the three receive status flags (framing error, parity error, break) that a status register shows for a receive FIFO. Each character in the FIFO carries its own three error bits. The FIFO storage and the receiver sit outside this block. The block watches the FIFO's write stream and read stream, plus the FIFO head, and turns them into the flags.

In character mode the flags follow only the character now at the FIFO head. In block mode each flag is a sticky OR of that error bit over every qualifying character since the last clear command. A command picks the point at which a character qualifies. At the entry point a character qualifies when it is written into the FIFO. At the exit point it qualifies when it is read out. The entry point therefore reports an error earlier, while the bad character is still queued.

Both streams are valid/ready, and the block only taps them. A transfer counts in the cycle where valid and ready are both high. The block never drives ready and never applies back-pressure. A cycle in which valid is held high against a low ready counts as no transfer. The control inputs are plain single-cycle levels or pulses.

Top module: `rxerr_status`

## Requirements
- R1: While reset is held, and in the first cycle after it, all three flags read 0 and the accumulation point is the entry point.
- R2: In character mode (`blk_mode`=0) with `head_valid`=1, the flags equal `head_err` one clock after it is presented. The bit mapping is bit 0 to framing, bit 1 to parity and bit 2 to break.
- R3: In character mode with `head_valid`=0, all three flags read 0 one clock later.
- R4: In block mode at the entry point, a write transfer with any `wr_err` bit set makes the matching flag 1 one clock later. The flag stays 1 until a clear.
- R5: In block mode at the exit point, a read transfer makes each `head_err` bit that is set at that moment sticky in the matching flag. Write transfers do not accumulate at the exit point.
- R6: A stream beat whose valid is high while its ready is low accumulates nothing.
- R7: `cmd_clr` clears all three accumulated flags one clock later. If a qualifying error arrives in the same cycle as the clear, that error is kept.
- R8: A pulse on `cmd_exit` selects the exit point and a pulse on `cmd_entry` selects the entry point. The new point takes effect from the next cycle, and if both pulse together the entry point wins. Changing the point never clears the accumulated flags.
- R9: Nothing accumulates while in character mode. The flags follow `blk_mode` one clock after it changes, so returning to block mode shows the accumulated value held before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_mode | input | 1 | 0 character mode, 1 block mode |
| cmd_entry | input | 1 | Pulse: accumulate at FIFO entry |
| cmd_exit | input | 1 | Pulse: accumulate at FIFO exit |
| cmd_clr | input | 1 | Pulse: clear accumulated errors |
| wr_valid | input | 1 | Write stream valid (tapped) |
| wr_ready | input | 1 | Write stream ready (tapped) |
| wr_err | input | 3 | Error bits of the character being written |
| rd_valid | input | 1 | Read stream valid (tapped) |
| rd_ready | input | 1 | Read stream ready (tapped) |
| head_valid | input | 1 | FIFO holds at least one character |
| head_err | input | 3 | Error bits of the character at the FIFO head |
| stat_fe | output | 1 | Framing error flag |
| stat_pe | output | 1 | Parity error flag |
| stat_brk | output | 1 | Break flag |

## Verification
Every flag lands exactly one clock after the inputs that cause it. This holds for the head view, the accumulator update, the clear and the mode select. A point-change command affects only transfers from the following cycle on. The bench drives one cycle of stimulus just after a falling edge and predicts the flags from its own FIFO model, then queues that prediction. The monitor pops the prediction at the next falling edge, after the one rising edge has registered the result, so each check samples the cycle where the result is due.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NFLAG = 3;
  localparam int FLAG_FE  = 0;
  localparam int FLAG_PE  = 1;
  localparam int FLAG_BRK = 2;

  typedef enum logic {
    PT_ENTRY = 1'b0,
    PT_EXIT  = 1'b1
  } acc_point_e;
endpackage

// File: rtl/rxerr_point_ctl.sv
module rxerr_point_ctl
  import rxerr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_entry,
  input  logic       cmd_exit,
  output acc_point_e point
);
  acc_point_e point_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         point_q <= PT_ENTRY;
    else if (cmd_entry) point_q <= PT_ENTRY;
    else if (cmd_exit)  point_q <= PT_EXIT;
  end

  assign point = point_q;

  p_exit_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exit && !cmd_entry) |=> (point == PT_EXIT));
  p_entry_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_entry |=> (point == PT_ENTRY));
endmodule

// File: rtl/rxerr_accum.sv
module rxerr_accum
  import rxerr_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  acc_point_e   point,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_err,
  input  logic         rd_fire,
  input  logic [W-1:0] rd_err,
  input  logic         clr,
  output logic [W-1:0] acc
);
  logic [W-1:0] qual;
  logic [W-1:0] acc_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      qual[i] = 1'b0;
      if (en) begin
        if (point == PT_ENTRY) qual[i] = wr_fire && wr_err[i];
        else                   qual[i] = rd_fire && rd_err[i];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       acc_q[i] <= 1'b0;
      else if (clr)     acc_q[i] <= qual[i];
      else if (qual[i]) acc_q[i] <= 1'b1;
    end
  end

  assign acc = acc_q;

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((acc & $past(acc)) == $past(acc)));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (acc == '0));
  p_keep_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && en && point == PT_ENTRY && wr_fire) |=> ((acc & $past(wr_err)) == $past(wr_err)));
  p_idle_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc));
endmodule

// File: rtl/rxerr_head_view.sv
module rxerr_head_view #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         head_valid,
  input  logic [W-1:0] head_err,
  output logic [W-1:0] view
);
  logic [W-1:0] view_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          view_q <= '0;
    else if (head_valid) view_q <= head_err;
    else                 view_q <= '0;
  end

  assign view = view_q;

  p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid |=> (view == '0));
endmodule

// File: rtl/rxerr_status.sv
module rxerr_status
  import rxerr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_mode,
  input  logic       cmd_entry,
  input  logic       cmd_exit,
  input  logic       cmd_clr,
  input  logic       wr_valid,
  input  logic       wr_ready,
  input  logic [2:0] wr_err,
  input  logic       rd_valid,
  input  logic       rd_ready,
  input  logic       head_valid,
  input  logic [2:0] head_err,
  output logic       stat_fe,
  output logic       stat_pe,
  output logic       stat_brk
);
  logic             wr_fire, rd_fire;
  logic             mode_q;
  acc_point_e       point;
  logic [NFLAG-1:0] acc, view, flags;

  assign wr_fire = wr_valid && wr_ready;
  assign rd_fire = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= blk_mode;
  end

  rxerr_point_ctl u_point (
    .clk(clk), .rst_n(rst_n),
    .cmd_entry(cmd_entry), .cmd_exit(cmd_exit),
    .point(point)
  );

  rxerr_accum #(.W(NFLAG)) u_accum (
    .clk(clk), .rst_n(rst_n),
    .en(blk_mode), .point(point),
    .wr_fire(wr_fire), .wr_err(wr_err),
    .rd_fire(rd_fire), .rd_err(head_err),
    .clr(cmd_clr), .acc(acc)
  );

  rxerr_head_view #(.W(NFLAG)) u_view (
    .clk(clk), .rst_n(rst_n),
    .head_valid(head_valid), .head_err(head_err),
    .view(view)
  );

  assign flags    = mode_q ? acc : view;
  assign stat_fe  = flags[FLAG_FE];
  assign stat_pe  = flags[FLAG_PE];
  assign stat_brk = flags[FLAG_BRK];

  p_no_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && mode_q && !cmd_clr && !wr_fire && !rd_fire)
      |=> ({stat_brk, stat_pe, stat_fe} == $past({stat_brk, stat_pe, stat_fe})));
  p_entry_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && point == PT_ENTRY && wr_fire && wr_err[FLAG_FE]) |=> stat_fe);
endmodule

// File: tb/rxerr_status_bench.sv
module rxerr_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_mode = 0, cmd_entry = 0, cmd_exit = 0, cmd_clr = 0;
  logic wr_valid = 0, wr_ready = 0, rd_valid = 0, rd_ready = 0, head_valid = 0;
  logic [2:0] wr_err = 0, head_err = 0;
  logic stat_fe, stat_pe, stat_brk;

  int checks = 0;
  int errors = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [10:0] fifo[$];
  logic [2:0] ref_acc = 0;
  logic       ref_exit = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  rxerr_status u_rxerr_status (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode),
    .cmd_entry(cmd_entry), .cmd_exit(cmd_exit), .cmd_clr(cmd_clr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_err(wr_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready),
    .head_valid(head_valid), .head_err(head_err),
    .stat_fe(stat_fe), .stat_pe(stat_pe), .stat_brk(stat_brk)
  );

  task automatic compare(input logic [2:0] exp, input string tag);
    logic [2:0] act;
    act = {stat_brk, stat_pe, stat_fe};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags actual %b expected %b", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; prediction queued for the monitor
  task automatic step(input logic mode, input logic wv, input logic wr,
                      input logic [2:0] werr, input logic [7:0] wdata,
                      input logic rr, input logic c_ent, input logic c_exit,
                      input logic c_clr, input string tag);
    logic [2:0] hd, qual, vw;
    logic       hv, wf, rf;
    @(negedge clk); #1;
    hv = (fifo.size() != 0);
    hd = hv ? fifo[0][10:8] : 3'b000;
    blk_mode = mode; wr_valid = wv; wr_ready = wr; wr_err = werr;
    rd_valid = hv; rd_ready = rr; head_valid = hv; head_err = hd;
    cmd_entry = c_ent; cmd_exit = c_exit; cmd_clr = c_clr;
    wf = wv && wr;
    rf = hv && rr;
    qual = 3'b000;
    if (mode) qual = ref_exit ? (rf ? hd : 3'b000) : (wf ? werr : 3'b000);
    ref_acc = c_clr ? qual : (ref_acc | qual);
    if (c_ent) ref_exit = 1'b0;
    else if (c_exit) ref_exit = 1'b1;
    vw = hv ? hd : 3'b000;
    exp_q.push_back(mode ? ref_acc : vw);
    tag_q.push_back(tag);
    if (rf) void'(fifo.pop_front());
    if (wf) fifo.push_back({werr, wdata});
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(3'b000, "R1 flags in reset");
    #1 rst_n = 1'b1;
    @(negedge clk);
    compare(3'b000, "R1 flags after reset");

    // character mode
    step(0, 1, 1, 3'b001, 8'h10, 0, 0, 0, 0, "R3 empty head");
    step(0, 1, 1, 3'b110, 8'h11, 0, 0, 0, 0, "R2 head fe");
    step(0, 0, 0, 3'b000, 8'h00, 1, 0, 0, 0, "R2 head fe read");
    step(0, 0, 0, 3'b000, 8'h00, 1, 0, 0, 0, "R2 head pe brk read");
    step(0, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R3 drained");

    // block mode, entry point
    step(1, 1, 0, 3'b111, 8'h20, 0, 0, 0, 0, "R6 write not ready");
    step(1, 0, 1, 3'b111, 8'h21, 0, 0, 0, 0, "R6 ready not valid");
    step(1, 1, 1, 3'b010, 8'h22, 0, 0, 0, 0, "R4 pe on entry");
    step(1, 1, 1, 3'b000, 8'h23, 0, 0, 0, 0, "R4 pe sticky");
    step(1, 1, 1, 3'b100, 8'h24, 1, 0, 0, 0, "R4 brk on entry");
    step(1, 0, 0, 3'b000, 8'h00, 1, 0, 0, 0, "R4 read not counted at entry");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 1, "R7 clear");
    step(1, 1, 1, 3'b001, 8'h25, 0, 0, 0, 1, "R7 clear keeps new fe");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R7 fe kept");

    // switch to exit point: accumulators kept
    step(1, 1, 1, 3'b010, 8'h26, 0, 0, 1, 0, "R8 cmd cycle still entry");
    step(1, 1, 1, 3'b100, 8'h27, 0, 0, 0, 0, "R5 write ignored at exit");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 1, "R7 clear at exit");
    while (fifo.size() != 0)
      step(1, 0, 0, 3'b000, 8'h00, 1, 0, 0, 0, "R5 read accumulates");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R5 held");

    // both commands: entry wins, nothing cleared
    step(1, 0, 0, 3'b000, 8'h00, 0, 1, 1, 0, "R8 both cmds");
    step(1, 1, 1, 3'b000, 8'h30, 0, 0, 0, 1, "R7 clear idle");
    step(1, 1, 1, 3'b001, 8'h31, 0, 0, 0, 0, "R8 entry restored");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 1, 0, "R8 switch keeps acc");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R8 acc after switch");

    // character mode does not accumulate
    step(0, 0, 0, 3'b000, 8'h00, 1, 1, 0, 0, "R9 char view");
    step(0, 1, 1, 3'b110, 8'h32, 0, 0, 0, 0, "R9 char no accum");
    step(0, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R9 char head");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R9 block shows old acc");
    step(1, 0, 0, 3'b000, 8'h00, 1, 0, 0, 0, "R9 entry read ignored");
    step(1, 0, 0, 3'b000, 8'h00, 0, 0, 0, 0, "R9 final");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule